// File: doc/BRIEF.md
# Multi-Cycle 16-Bit Load/Store Processor Core

This block is a small processor core that executes four instruction types from a 16-bit instruction set: register-to-register addition, load from base register plus offset, store to base register plus offset, and an unconditional jump through a register. It holds eight 16-bit general registers, a program counter, an instruction register, and the memory address and memory data registers. Each instruction passes through a fixed sequence of phases. The phases are fetch, decode, address evaluation, operand fetch, execute and result store. An opcode skips the phases it has no use for, so each instruction type takes a fixed number of cycles.

The core connects to word-addressed memory through one synchronous port. The address always comes from the memory address register. Read data is taken on the cycle after a read request. A write completes at the clock edge that ends the cycle in which the write strobe is high. When the core decodes an opcode it does not support, it treats the instruction as a no-op and raises a sticky halt flag, which tells the environment that the program has reached its end.

Top module: `cpu_core`

## Requirements
- R1: Synchronous active-high reset clears PC, all registers and the halt flag, and puts the core in the first fetch phase. In the first cycle after reset no memory access is made. In the second cycle a read is issued at address 0.
- R2: Fetch takes three cycles and decode takes one. The first fetch cycle copies PC into the address register. The second issues a read and increments PC by one. The third loads the returned word into the instruction register, and the opcode sits in bits [15:12].
- R3: ADD (opcode 0001, destination [11:9], first source [8:6], second source [2:0]) writes the 16-bit sum of the two sources, modulo 2^16, into the destination. Any of R0 to R7 may be the destination. The instruction takes 7 cycles.
- R4: LDR (opcode 0110, destination [11:9], base [8:6], offset [5:0]) reads the word at base + offset into the destination without using the ALU sum. The instruction takes 8 cycles.
- R5: STR (opcode 0111, source [11:9], base [8:6], offset [5:0]) writes the source register to memory at base + offset. The write strobe is high for exactly one cycle, and the instruction takes 7 cycles.
- R6: JMP (opcode 1100, base [8:6], all other fields zero) replaces the already incremented PC with the base register during execute, so the next fetch reads from that address. The instruction takes 5 cycles.
- R7: The 6-bit offset is sign-extended to 16 bits before it is added to the base. The address sum wraps modulo 2^16, so offsets from -32 to +31 are reachable.
- R8: Any other opcode changes no register and no memory word, and sets a halt flag that stays set until reset. The core then returns to fetch after 4 cycles.
- R9: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Word address for the memory port |
| mem_rd | output | 1 | Read request; data is expected on mem_rdata the next cycle |
| mem_wr | output | 1 | Write strobe; memory stores mem_wdata at the clock edge |
| mem_wdata | output | 16 | Data to be written |
| mem_rdata | input | 16 | Read data returned one cycle after mem_rd |
| halt | output | 1 | Sticky flag set when an unsupported opcode is decoded |

## Verification
The bench builds the core with its default 16-bit data width and eight registers. With this configuration, negative and maximum-positive 6-bit offsets reach both ends of a 256-word memory model, and an addition of 0xFFFF to itself shows the sum wrapping at 16 bits. The program loads operands, adds them, stores the results and jumps over a store that must not take effect. After the jump it writes through a non-zero base register and through R0 used as a destination. Every result reaches the bench through stores. The exact cycle at which halt rises, together with the counts of reads and writes, confirms the cycle cost of every instruction type.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam int WORD_W = 16;
    localparam int OPC_W  = 4;
    localparam int RSEL_W = 3;
    localparam int OFS_W  = 6;

    localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_LDR = 4'b0110;
    localparam logic [OPC_W-1:0] OPC_STR = 4'b0111;
    localparam logic [OPC_W-1:0] OPC_JMP = 4'b1100;

    typedef enum logic [2:0] {
        PH_FI_ADDR,
        PH_FI_READ,
        PH_FI_LOAD,
        PH_DECODE,
        PH_EVAL_ADDR,
        PH_FETCH_OPND,
        PH_EXECUTE,
        PH_STORE_RES
    } phase_e;

    typedef enum logic [2:0] {
        K_ADD,
        K_LDR,
        K_STR,
        K_JMP,
        K_NOP
    } kind_e;

    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [RSEL_W-1:0] f_hi;
        logic [RSEL_W-1:0] f_mid;
        logic [OFS_W-1:0]  f_lo;
    } instr_t;

    function automatic kind_e classify(input logic [OPC_W-1:0] opc);
        case (opc)
            OPC_ADD: return K_ADD;
            OPC_LDR: return K_LDR;
            OPC_STR: return K_STR;
            OPC_JMP: return K_JMP;
            default: return K_NOP;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] widen_ofs(input logic [OFS_W-1:0] ofs);
        return {{(WORD_W-OFS_W){ofs[OFS_W-1]}}, ofs};
    endfunction

endpackage

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
    parameter int DATA_W = 16,
    parameter int NREGS  = 8,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  ra1,
    input  logic [IDX_W-1:0]  ra2,
    output logic [DATA_W-1:0] rd1,
    output logic [DATA_W-1:0] rd2,
    input  logic              we,
    input  logic [IDX_W-1:0]  wa,
    input  logic [DATA_W-1:0] wd
);
    logic [DATA_W-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        we |=> regs[$past(wa)] == $past(wd)); // R3
endmodule

// File: rtl/cpu_adder.sv
module cpu_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    assign s = a + b;
endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
    import cpu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  kind_e  kind,
    output phase_e phase,
    output logic   halt
);
    phase_e nxt;

    always_comb begin
        nxt = PH_FI_ADDR;
        case (phase)
            PH_FI_ADDR:    nxt = PH_FI_READ;
            PH_FI_READ:    nxt = PH_FI_LOAD;
            PH_FI_LOAD:    nxt = PH_DECODE;
            PH_DECODE: begin
                case (kind)
                    K_ADD:        nxt = PH_FETCH_OPND;
                    K_LDR, K_STR: nxt = PH_EVAL_ADDR;
                    K_JMP:        nxt = PH_EXECUTE;
                    default:      nxt = PH_FI_ADDR;
                endcase
            end
            PH_EVAL_ADDR:  nxt = PH_FETCH_OPND;
            PH_FETCH_OPND: nxt = (kind == K_STR) ? PH_STORE_RES : PH_EXECUTE;
            PH_EXECUTE:    nxt = (kind == K_JMP) ? PH_FI_ADDR : PH_STORE_RES;
            PH_STORE_RES:  nxt = PH_FI_ADDR;
            default:       nxt = PH_FI_ADDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FI_ADDR;
            halt  <= 1'b0;
        end else begin
            phase <= nxt;
            if (phase == PH_DECODE && kind == K_NOP) halt <= 1'b1;
        end
    end

    AST_RESET_FETCH: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (phase == PH_FI_ADDR && !halt)); // R1
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halt |=> halt); // R8
    AST_NOP_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DECODE && kind == K_NOP) |=> (phase == PH_FI_ADDR && halt)); // R8
endmodule

// File: rtl/cpu_core.sv
module cpu_core
    import cpu_pkg::*;
#(
    parameter int NREGS = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic [WORD_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              halt
);
    logic [WORD_W-1:0] pc, mar, mdr, opa, opb, res;
    instr_t            ir;
    phase_e            phase;
    kind_e             kind;

    logic [RSEL_W-1:0] ra2;
    logic [WORD_W-1:0] rd1, rd2, ofs_x;
    logic [WORD_W-1:0] add_a, add_b, add_s;
    logic              rf_we;
    logic [WORD_W-1:0] rf_wd;

    assign kind  = classify(ir.opc);
    assign ofs_x = widen_ofs(ir.f_lo);
    assign ra2   = (kind == K_STR) ? ir.f_hi : ir.f_lo[RSEL_W-1:0];

    cpu_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .kind  (kind),
        .phase (phase),
        .halt  (halt)
    );

    cpu_regfile #(.DATA_W(WORD_W), .NREGS(NREGS)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (ir.f_mid),
        .ra2 (ra2),
        .rd1 (rd1),
        .rd2 (rd2),
        .we  (rf_we),
        .wa  (ir.f_hi),
        .wd  (rf_wd)
    );

    // One adder serves both address evaluation and ADD execution.
    assign add_a = (phase == PH_EVAL_ADDR) ? rd1   : opa;
    assign add_b = (phase == PH_EVAL_ADDR) ? ofs_x : opb;

    cpu_adder #(.W(WORD_W)) u_add (
        .a (add_a),
        .b (add_b),
        .s (add_s)
    );

    assign rf_we = (phase == PH_STORE_RES) && (kind == K_ADD || kind == K_LDR);
    assign rf_wd = (kind == K_ADD) ? res : mdr;

    assign mem_addr  = mar;
    assign mem_rd    = (phase == PH_FI_READ) || (phase == PH_FETCH_OPND && kind == K_LDR);
    assign mem_wr    = (phase == PH_STORE_RES) && (kind == K_STR);
    assign mem_wdata = mdr;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            mar <= '0;
            mdr <= '0;
            ir  <= '0;
            opa <= '0;
            opb <= '0;
            res <= '0;
        end else begin
            case (phase)
                PH_FI_ADDR: mar <= pc;
                PH_FI_READ: pc  <= pc + 1'b1;
                PH_FI_LOAD: begin
                    ir  <= mem_rdata;
                    mdr <= mem_rdata;
                end
                PH_EVAL_ADDR: mar <= add_s;
                PH_FETCH_OPND: begin
                    if (kind == K_ADD) begin
                        opa <= rd1;
                        opb <= rd2;
                    end
                    if (kind == K_STR) mdr <= rd2;
                end
                PH_EXECUTE: begin
                    if (kind == K_ADD) res <= add_s;
                    if (kind == K_LDR) mdr <= mem_rdata;
                    if (kind == K_JMP) pc  <= rd1;
                end
                default: ;
            endcase
        end
    end

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FI_READ) |=> pc == $past(pc) + 16'd1); // R2
    AST_JMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXECUTE && kind == K_JMP) |=> pc == $past(rd1)); // R6
    AST_EA_WRAP: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EVAL_ADDR) |=> mar == $past(rd1) + widen_ofs($past(ir.f_lo))); // R7
    AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> !mem_wr); // R5
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R9
endmodule

// File: tb/sim_cpu_core.sv
module sim_cpu_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr, halt;

    logic [15:0] mem [256];
    int n_chk = 0, n_bad = 0;
    int n_rd = 0, n_wr = 0, n_both = 0;
    bit counting = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cpu_core u0 (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halt(halt)
    );

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    end

    always @(negedge clk) begin
        if (counting) begin
            if (mem_rd) n_rd++;
            if (mem_wr) n_wr++;
            if (mem_rd && mem_wr) n_both++;
        end
    end

    // Expected memory words after the run: {address, value}
    localparam logic [31:0] EXPECT [6] = '{
        {16'h00F0, 16'h2224},
        {16'h00F1, 16'hFFFE},
        {16'h00F2, 16'h0FEF},
        {16'h00F3, 16'hDEAD},
        {16'h000F, 16'hBEEF},
        {16'h002F, 16'hBEFF}
    };

    function automatic string tag_of(int i);
        case (i)
            0: return "R3 add";
            1: return "R3 wrap";
            2: return "R7 neg offset";
            3: return "R6 jump skip";
            4: return "R4 base load";
            default: return "R3 dest R0";
        endcase
    endfunction

    function automatic logic [15:0] e_add(int d, int a, int b);
        return {4'b0001, 3'(d), 3'(a), 3'b000, 3'(b)};
    endfunction
    function automatic logic [15:0] e_ldr(int d, int b, int o);
        return {4'b0110, 3'(d), 3'(b), 6'(o)};
    endfunction
    function automatic logic [15:0] e_str(int s, int b, int o);
        return {4'b0111, 3'(s), 3'(b), 6'(o)};
    endfunction
    function automatic logic [15:0] e_jmp(int b);
        return {4'b1100, 3'b000, 3'(b), 6'b000000};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=halt");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int cyc;
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        mem[8'hE0] = 16'h1234;
        mem[8'hE1] = 16'h0FF0;
        mem[8'hE2] = 16'hFFFF;
        mem[8'hE3] = 16'h0010;
        mem[8'hF3] = 16'hDEAD;
        mem[8'h15] = 16'hBEEF;
        mem[8'h00] = e_ldr(1, 0, -32);
        mem[8'h01] = e_ldr(2, 0, -31);
        mem[8'h02] = e_ldr(3, 0, -30);
        mem[8'h03] = e_add(4, 1, 2);
        mem[8'h04] = e_add(5, 3, 3);
        mem[8'h05] = e_add(6, 2, 3);
        mem[8'h06] = e_str(4, 0, -16);
        mem[8'h07] = e_str(5, 0, -15);
        mem[8'h08] = e_str(6, 0, -14);
        mem[8'h09] = e_ldr(7, 0, -29);
        mem[8'h0A] = e_jmp(7);
        mem[8'h0B] = e_str(1, 0, -13);
        mem[8'h10] = e_ldr(1, 7, 5);
        mem[8'h11] = e_str(1, 7, -1);
        mem[8'h12] = e_add(0, 7, 1);
        mem[8'h13] = e_str(0, 7, 31);
        mem[8'h14] = 16'hF000;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        counting = 1'b1;
        // R1: first cycle after reset has no access and halt low
        check("R1 halt after reset", {31'd0, halt}, 32'd0);
        check("R1 no access first cycle", {30'd0, mem_rd, mem_wr}, 32'd0);
        @(posedge clk);
        cyc = 1;
        @(negedge clk);
        // R2: second cycle reads at PC = 0
        check("R2 first fetch read", {15'd0, mem_rd, mem_addr}, {15'd0, 1'b1, 16'h0000});
        while (!halt && cyc < 1000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        counting = 1'b0;
        // R2 R3 R4 R5 R6 R8: per-type cycle costs sum to 112
        check("R8 halt cycle", 32'(cyc), 32'd112);
        check("R5 write count", 32'(n_wr), 32'd5);
        check("R4 read count", 32'(n_rd), 32'd21);
        check("R9 strobe overlap", 32'(n_both), 32'd0);
        for (int i = 0; i < 6; i++)
            check(tag_of(i), {16'd0, mem[EXPECT[i][23:16]]}, {16'd0, EXPECT[i][15:0]});
        check("R4 source data kept", {16'd0, mem[8'hE0]}, 32'h1234);
        repeat (20) @(posedge clk);
        @(negedge clk);
        check("R8 halt sticky", {31'd0, halt}, 32'd1);
        // R1: reset clears halt again
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset clears halt", {31'd0, halt}, 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule